// File: doc/BRIEF.md
# PWM Fault Trip Guard

This block sits in the path from a PWM generator to the output pads and overrides the PWM drive when a fault is present. It watches six active-low fault lines. Each line can be routed to a latched trip, to a per-cycle trip, or to both. A latched trip is meant for a catastrophic fault. It holds the outputs in their safe state until software clears it. A per-cycle trip is meant for current limiting. It releases at the next cycle-start strobe from the PWM counter, provided the fault has gone away by then.

Each output has two programmable safe actions, one for each trip kind: drive low, drive high, release to high impedance, or leave the PWM untouched. High impedance appears as an output-enable bit that drops for that output. A latched-trip status flag, a sticky per-cycle status flag and a sticky interrupt request are provided, each with its own clear strobe. The fault lines are synchronized inside the block.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset no trip is active, every pwmOut equals its pwmIn, every pwmOe is 1, and oneShotFlag, cycleFlag and irq are 0.
- R2: A fault line whose bit is 0 in both oneShotEn and cycleEn has no effect on outputs, flags or irq.
- R3: A fault line is passed through two synchronizing flops. An enabled fault driven low before a clock edge leaves the outputs unchanged after that first edge and forces them after the second edge.
- R4: Each output uses a 2-bit action field, at bits [2i+1:2i] of oneShotAct or cycleAct. The codes are: 0 drives the output low with pwmOe=1; 1 drives it high with pwmOe=1; 2 gives pwmOe=0 with pwmOut=0; 3 passes pwmIn with pwmOe=1.
- R5: A latched trip remains in force after its fault goes away, and also through cycleStart strobes, until a clrOneShot pulse arrives while no latched-trip fault is active. A clear pulse that comes while the fault is still active has no effect.
- R6: A per-cycle trip stays in force while its fault is active, even across a cycleStart. Once the fault is gone, the trip is released at the next cycleStart pulse and not before.
- R7: While a latched trip is in force, each output follows oneShotAct, even when a per-cycle trip is also in force. When the latched trip is cleared, a per-cycle trip that is still in force applies cycleAct again.
- R8: oneShotFlag shows the latched-trip state one clock after the synchronized fault. cycleFlag is set by any per-cycle fault and stays set until a clrCycle pulse arrives while no per-cycle fault is active.
- R9: irq is set by any enabled fault of either kind. It stays set until a clrInt pulse arrives while no enabled fault is active.
- R10: A fault line enabled in both oneShotEn and cycleEn sets both oneShotFlag and cycleFlag, and the outputs follow oneShotAct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| faultN | input | 6 | Asynchronous fault lines, active low |
| pwmIn | input | 2 | PWM drive from the generator |
| cycleStart | input | 1 | One-clock strobe at counter zero |
| oneShotEn | input | 6 | Routes each fault line to the latched trip |
| cycleEn | input | 6 | Routes each fault line to the per-cycle trip |
| oneShotAct | input | 4 | Per-output action codes used by the latched trip |
| cycleAct | input | 4 | Per-output action codes used by the per-cycle trip |
| clrOneShot | input | 1 | Clear pulse for the latched trip |
| clrCycle | input | 1 | Clear pulse for cycleFlag |
| clrInt | input | 1 | Clear pulse for irq |
| pwmOut | output | 2 | Guarded PWM level |
| pwmOe | output | 2 | Output enable, 0 means high impedance |
| oneShotFlag | output | 1 | Latched trip in force |
| cycleFlag | output | 1 | Sticky per-cycle trip status |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is a per-cycle trip that is still latched after its fault has gone and before the next cycleStart. Reaching it means releasing the fault line, waiting out the two synchronizer stages, and then holding cycleStart back. Only then does the stimulus give the strobe, so the release is seen on exactly that edge. The precedence case is reached in a similar way. A per-cycle fault is raised first, a latched fault is added on top of it, and then the latched trip is cleared on its own. This shows the per-cycle action returning without any new fault edge.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_HIZ  = 2'd2,
    ACT_PASS = 2'd3
  } actCode_t;

  typedef struct packed {
    logic oneShotOn;
    logic cycleOn;
  } tripStrobe_t;
endpackage

// File: rtl/ptg_sync.sv
module ptg_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncN,
  output logic [WIDTH-1:0] syncN
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      syncN  <= '1;
    end else begin
      stage1 <= asyncN;
      syncN  <= stage1;
    end
  end
endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultSyncN,
  input  logic [NUM_SRC-1:0] oneShotEn,
  input  logic [NUM_SRC-1:0] cycleEn,
  input  logic               cycleStart,
  input  logic               clrOneShot,
  input  logic               clrCycle,
  input  logic               clrInt,
  output tripStrobe_t        strobe,
  output logic               oneShotFlag,
  output logic               cycleFlag,
  output logic               irq
);
  logic [NUM_SRC-1:0] faultOn;
  logic oneShotHit, cycleHit;
  logic oneShotLatch, cycleLatch, cycleSticky, intSticky;

  assign faultOn    = ~faultSyncN;
  assign oneShotHit = |(faultOn & oneShotEn);
  assign cycleHit   = |(faultOn & cycleEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneShotLatch <= 1'b0;
      cycleLatch   <= 1'b0;
      cycleSticky  <= 1'b0;
      intSticky    <= 1'b0;
    end else begin
      oneShotLatch <= oneShotHit | (oneShotLatch & ~clrOneShot);
      cycleLatch   <= cycleHit   | (cycleLatch & ~cycleStart);
      cycleSticky  <= cycleHit   | (cycleSticky & ~clrCycle);
      intSticky    <= oneShotHit | cycleHit | (intSticky & ~clrInt);
    end
  end

  assign strobe.oneShotOn = oneShotLatch | oneShotHit;
  assign strobe.cycleOn   = cycleLatch | cycleHit;
  assign oneShotFlag      = oneShotLatch;
  assign cycleFlag        = cycleSticky;
  assign irq              = intSticky;
endmodule

// File: rtl/ptg_outmux.sv
module ptg_outmux
  import ptg_pkg::*;
#(
  parameter int NUM_OUT = 2,
  localparam int ACT_W = 2 * NUM_OUT
) (
  input  logic [NUM_OUT-1:0] pwmIn,
  input  logic [ACT_W-1:0]   oneShotAct,
  input  logic [ACT_W-1:0]   cycleAct,
  input  tripStrobe_t        strobe,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic [NUM_OUT-1:0] pwmOe
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    actCode_t sel;
    always_comb begin
      if (strobe.oneShotOn)    sel = actCode_t'(oneShotAct[2*i +: 2]);
      else if (strobe.cycleOn) sel = actCode_t'(cycleAct[2*i +: 2]);
      else                     sel = ACT_PASS;
      case (sel)
        ACT_LOW:  begin pwmOut[i] = 1'b0;     pwmOe[i] = 1'b1; end
        ACT_HIGH: begin pwmOut[i] = 1'b1;     pwmOe[i] = 1'b1; end
        ACT_HIZ:  begin pwmOut[i] = 1'b0;     pwmOe[i] = 1'b0; end
        default:  begin pwmOut[i] = pwmIn[i]; pwmOe[i] = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
  import ptg_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int NUM_OUT = 2,
  localparam int ACT_W = 2 * NUM_OUT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] faultN,
  input  logic [NUM_OUT-1:0] pwmIn,
  input  logic               cycleStart,
  input  logic [NUM_SRC-1:0] oneShotEn,
  input  logic [NUM_SRC-1:0] cycleEn,
  input  logic [ACT_W-1:0]   oneShotAct,
  input  logic [ACT_W-1:0]   cycleAct,
  input  logic               clrOneShot,
  input  logic               clrCycle,
  input  logic               clrInt,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic [NUM_OUT-1:0] pwmOe,
  output logic               oneShotFlag,
  output logic               cycleFlag,
  output logic               irq
);
  logic [NUM_SRC-1:0] faultSyncN;
  tripStrobe_t        strobe;

  ptg_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rstN(rstN), .asyncN(faultN), .syncN(faultSyncN)
  );

  ptg_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .faultSyncN(faultSyncN),
    .oneShotEn(oneShotEn), .cycleEn(cycleEn), .cycleStart(cycleStart),
    .clrOneShot(clrOneShot), .clrCycle(clrCycle), .clrInt(clrInt),
    .strobe(strobe), .oneShotFlag(oneShotFlag), .cycleFlag(cycleFlag),
    .irq(irq)
  );

  ptg_outmux #(.NUM_OUT(NUM_OUT)) u_mux (
    .pwmIn(pwmIn), .oneShotAct(oneShotAct), .cycleAct(cycleAct),
    .strobe(strobe), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int NUM_OUT = 2,
  localparam int ACT_W = 2 * NUM_OUT
) (
  input logic               clk,
  input logic               rstN,
  input logic               clrOneShot,
  input logic               clrCycle,
  input logic               clrInt,
  input logic               oneShotFlag,
  input logic               cycleFlag,
  input logic               irq,
  input logic [NUM_OUT-1:0] pwmOut,
  input logic [NUM_OUT-1:0] pwmOe,
  input logic [ACT_W-1:0]   oneShotAct
);
  a_r5_oneshot_holds: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotFlag && !clrOneShot) |=> oneShotFlag);

  a_r8_cycle_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cycleFlag && !clrCycle) |=> cycleFlag);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrInt) |=> irq);

  a_r7_oneshot_wins: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotFlag && oneShotAct[1:0] == 2'd0) |-> (!pwmOut[0] && pwmOe[0]));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hiz
    a_r4_hiz_drives_low: assert property (@(posedge clk) disable iff (!rstN)
      !pwmOe[i] |-> !pwmOut[i]);
  end
endmodule

bind pwm_trip_guard ptg_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .clrOneShot(clrOneShot), .clrCycle(clrCycle),
  .clrInt(clrInt), .oneShotFlag(oneShotFlag), .cycleFlag(cycleFlag),
  .irq(irq), .pwmOut(pwmOut), .pwmOe(pwmOe), .oneShotAct(oneShotAct)
);

// File: tb/test_pwm_trip_guard.sv
module test_pwm_trip_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] faultN = '1;
  logic [1:0] pwmIn = 2'b01;
  logic cycleStart = 1'b0;
  logic [5:0] oneShotEn = '0, cycleEn = '0;
  logic [3:0] oneShotAct = 4'hF, cycleAct = 4'hF;
  logic clrOneShot = 1'b0, clrCycle = 1'b0, clrInt = 1'b0;
  logic [1:0] pwmOut, pwmOe;
  logic oneShotFlag, cycleFlag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_trip_guard i_pwm_trip_guard (
    .clk(clk), .rstN(rstN), .faultN(faultN), .pwmIn(pwmIn),
    .cycleStart(cycleStart), .oneShotEn(oneShotEn), .cycleEn(cycleEn),
    .oneShotAct(oneShotAct), .cycleAct(cycleAct), .clrOneShot(clrOneShot),
    .clrCycle(clrCycle), .clrInt(clrInt), .pwmOut(pwmOut), .pwmOe(pwmOe),
    .oneShotFlag(oneShotFlag), .cycleFlag(cycleFlag), .irq(irq)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {oe,out} of one output for an action code
  function automatic logic [1:0] expPin(logic [1:0] code, logic pwm);
    case (code)
      2'd0: return 2'b10;
      2'd1: return 2'b11;
      2'd2: return 2'b00;
      default: return {1'b1, pwm};
    endcase
  endfunction

  task automatic checkPins(string req, logic [3:0] act);
    logic [1:0] e0, e1;
    e0 = expPin(act[1:0], pwmIn[0]);
    e1 = expPin(act[3:2], pwmIn[1]);
    check(req, {pwmOe, pwmOut}, {e1[1], e0[1], e1[0], e0[0]});
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic testReset();
    checkPins("R1 pins after reset", 4'hF);
    check("R1 flags after reset", {oneShotFlag, cycleFlag, irq}, 3'b000);
  endtask

  task automatic testDisabled();
    oneShotEn = 6'b111011; cycleEn = 6'b111011;
    oneShotAct = 4'h0; cycleAct = 4'h0;
    faultN[2] = 1'b0; tick(4);
    checkPins("R2 disabled line ignored", 4'hF);
    check("R2 flags stay clear", {oneShotFlag, cycleFlag, irq}, 3'b000);
    faultN[2] = 1'b1; tick(3);
    oneShotEn = '0; cycleEn = '0;
  endtask

  task automatic testLatchedTrip();
    oneShotEn = 6'b000001; oneShotAct = {2'd2, 2'd1};
    faultN[0] = 1'b0; tick();
    checkPins("R3 unchanged after first edge", 4'hF);
    tick();
    checkPins("R3 R4 forced after second edge", oneShotAct);
    tick();
    check("R8 oneShotFlag set", oneShotFlag, 1'b1);
    check("R9 irq set", irq, 1'b1);
    pulse(clrOneShot);
    checkPins("R5 clear ignored while active", oneShotAct);
    faultN[0] = 1'b1; tick(3);
    pulse(cycleStart);
    checkPins("R5 held through cycleStart", oneShotAct);
    check("R5 flag held", oneShotFlag, 1'b1);
    pulse(clrOneShot);
    checkPins("R5 released by clear", 4'hF);
    check("R5 flag cleared", oneShotFlag, 1'b0);
    pulse(clrInt);
    check("R9 irq cleared", irq, 1'b0);
    oneShotEn = '0;
  endtask

  task automatic testCycleTrip();
    cycleEn = 6'b001000; cycleAct = {2'd1, 2'd0};
    faultN[3] = 1'b0; tick(2);
    checkPins("R6 R4 per-cycle forced", cycleAct);
    tick();
    pulse(cycleStart);
    checkPins("R6 held while fault active", cycleAct);
    check("R8 cycleFlag set", cycleFlag, 1'b1);
    pulse(clrCycle);
    check("R8 clrCycle ignored while active", cycleFlag, 1'b1);
    faultN[3] = 1'b1; tick(4);
    checkPins("R6 held until cycleStart", cycleAct);
    pulse(cycleStart);
    checkPins("R6 released at cycleStart", 4'hF);
    check("R8 cycleFlag sticky", cycleFlag, 1'b1);
    pulse(clrCycle);
    check("R8 cycleFlag cleared", cycleFlag, 1'b0);
    pulse(clrInt);
    cycleEn = '0;
  endtask

  task automatic testPrecedence();
    oneShotEn = 6'b000010; cycleEn = 6'b010000;
    oneShotAct = {2'd3, 2'd0}; cycleAct = {2'd1, 2'd1};
    pwmIn = 2'b10;
    faultN[4] = 1'b0; tick(2);
    checkPins("R7 per-cycle alone", cycleAct);
    faultN[1] = 1'b0; tick(2);
    checkPins("R7 latched wins", oneShotAct);
    faultN[1] = 1'b1; faultN[4] = 1'b1; tick(3);
    pulse(clrOneShot);
    checkPins("R7 per-cycle action returns", cycleAct);
    pulse(cycleStart);
    checkPins("R7 all released", 4'hF);
    pulse(clrCycle); pulse(clrInt);
    oneShotEn = '0; cycleEn = '0;
  endtask

  task automatic testBothModes();
    oneShotEn = 6'b100000; cycleEn = 6'b100000;
    oneShotAct = {2'd0, 2'd2}; cycleAct = {2'd1, 2'd1};
    faultN[5] = 1'b0; tick(3);
    check("R10 both flags", {oneShotFlag, cycleFlag}, 2'b11);
    checkPins("R10 latched action shown", oneShotAct);
    pulse(clrInt);
    check("R9 clrInt ignored while active", irq, 1'b1);
    faultN[5] = 1'b1; tick(3);
    pulse(clrOneShot); pulse(cycleStart);
    checkPins("R10 released", 4'hF);
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    tick();
    testReset();
    testDisabled();
    testLatchedTrip();
    testCycleTrip();
    testPrecedence();
    testBothModes();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule